// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the device side of a serial NOR flash. A bus master selects it with an active-low chip select, clocks command bytes in on a serial input and receives reply bytes on a serial output. The block decodes each opcode and collects any address and data bytes that follow. It answers reads, identification queries and status queries from a small byte array held inside the block. It turns program, erase and status-write commands into work on that array. A status byte holds a busy flag, a write-enable latch and a three-bit protection level.

All bus pins are synchronised into the system clock domain, so the serial clock must be several system clocks slower than `clk`. Inside the block, the command decoder hands array work to the storage model over a valid/ready request port. The storage model drops ready while it walks an erase, one byte per clock. The decoder holds its request stable until ready is seen, and a one-cycle done pulse returns when the work is finished. The serial side has no back-pressure: reply bytes are produced as fast as the master clocks them. Write-class commands take effect only when chip select rises on the exact frame length. Program and erase durations are modelled by a busy counter of configurable length.

Top module: `spif_cmd_front`

## Requirements
- R1: The serial input is sampled on rising serial-clock edges, most significant bit first. A frame starts when chip select falls and ends when it rises. The idle serial-clock level may be low (mode 0) or high (mode 3).
- R2: `so_en` is high only while chip select is low and a reply is in progress. Reply bits change after falling serial-clock edges, most significant bit first. `so` is 0 while deselected.
- R3: Read (03h) plus three address bytes streams bytes from that address. The address increments after each byte and wraps from the top of the array (2^ADDR_W-1) to 0. Address bits at and above ADDR_W are ignored.
- R4: Opcode 9Fh returns BFh, DEV_ID[15:8] and DEV_ID[7:0], then repeats. Opcodes 90h and ABh, after three address bytes, alternate BFh and DEV_ID[7:0], starting with DEV_ID[7:0] when address bit 0 is 1.
- R5: Status read (05h) returns the live status byte again for every further byte of the frame. The status byte is: bit 0 busy, bit 1 write-enable latch, bits 4:2 protection level, other bits 0.
- R6: 06h sets and 04h clears the write-enable latch, each only when chip select rises after exactly 8 bits.
- R7: A write-class command acts at chip-select rise only when the latch is 1 and the bit count is exact. The write-class commands and their lengths are: status write 01h (16 bits), byte program 02h (40 bits), erases 20h, 52h and D8h (32 bits), and chip erase 60h or C7h (8 bits). Otherwise the command is dropped, with no busy period and no state change.
- R8: Status write loads the protection level from data bits 4:2. The level resets to 0.
- R9: Byte program ANDs the data byte into the addressed byte, so it can only clear bits.
- R10: Erase sets every byte of the aligned region that holds the address to FFh. The region is 2^SECT_W bytes for 20h, 2^SBLK_W bytes for 52h, 2^LBLK_W bytes for D8h, and the whole array for chip erase.
- R11: A protection level k other than 0 guards the top 2^ADDR_W >> (7-k) bytes. A program or block/sector erase that touches this range is dropped. Chip erase runs only at level 0.
- R12: An accepted write-class command sets busy for at least BUSY_CYCLES clocks and until the array work is done. Busy and the write-enable latch then clear together.
- R13: While busy, every opcode except 05h is ignored: there is no reply and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | High while `so` carries a reply |

## Verification
A reply bit appears on `so` about three system clocks after the falling serial-clock edge that launches it: two synchroniser stages plus the output register. The bench holds each serial-clock half period for six system clocks and samples `so` just before the next rising edge. Write-class effects occur a few clocks after chip select rises, so they are always checked in a later frame, either by a status read or by reading the array back. A scoreboard queue pairs each expected reply byte with the byte the monitor receives.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_SECT = 8'h20;
  localparam logic [7:0] OP_SBLK = 8'h52;
  localparam logic [7:0] OP_LBLK = 8'hD8;
  localparam logic [7:0] OP_CHPA = 8'h60;
  localparam logic [7:0] OP_CHPB = 8'hC7;
  localparam logic [7:0] OP_JID  = 8'h9F;
  localparam logic [7:0] OP_IDA  = 8'h90;
  localparam logic [7:0] OP_IDB  = 8'hAB;
  localparam logic [7:0] MFR_ID  = 8'hBF;

  typedef enum logic {ARR_PROG = 1'b0, ARR_ERASE = 1'b1} arr_op_e;
endpackage

// File: rtl/spif_sampler.sv
module spif_sampler #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[gi];
        s2 <= RST_VAL[gi];
        s3 <= RST_VAL[gi];
      end else begin
        s1 <= din[gi];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[gi]    = s2;
    assign rise[gi] = s2 & ~s3;
    assign fall[gi] = ~s2 & s3;
  end
endmodule

// File: rtl/spif_guard.sv
module spif_guard #(
  parameter int ADDR_W = 10
) (
  input  logic [2:0]        level,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W:0]   len,
  output logic              hit
);
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;

  logic [ADDR_W:0] guarded;
  logic [ADDR_W:0] last;

  always_comb begin
    guarded = FULL >> (3'd7 - level);
    last    = {1'b0, start} + len - (ADDR_W+1)'(1);
    hit     = (level != 3'd0) && (last >= FULL - guarded);
  end
endmodule

// File: rtl/spif_store.sv
module spif_store
  import spif_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  arr_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W:0]   req_len,
  input  logic [7:0]        req_data,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic              walking;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W:0]   left;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic              take;

  assign req_ready = ~walking;
  assign take      = req_valid & req_ready;

  always_comb begin
    we    = 1'b0;
    waddr = cur;
    wdata = 8'hFF;
    if (walking) begin
      we = 1'b1;
    end else if (take && req_op == ARR_PROG) begin
      we    = 1'b1;
      waddr = req_addr;
      wdata = mem[req_addr] & req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking <= 1'b0;
      cur     <= '0;
      left    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (walking) begin
        cur  <= cur + ADDR_W'(1);
        left <= left - (ADDR_W+1)'(1);
        if (left == (ADDR_W+1)'(1)) begin
          walking <= 1'b0;
          done    <= 1'b1;
        end
      end else if (take) begin
        if (req_op == ARR_PROG) begin
          done <= 1'b1;
        end else begin
          walking <= 1'b1;
          cur     <= req_addr;
          left    <= req_len;
        end
      end
    end
  end

  AST_STORE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) take |=> (walking || done)); // R12
endmodule

// File: rtl/spif_cmd_front.sv
module spif_cmd_front
  import spif_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          SECT_W      = 6,
  parameter int          SBLK_W      = 7,
  parameter int          LBLK_W      = 8,
  parameter logic [15:0] DEV_ID      = 16'h2514,
  parameter int          BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_en
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W:0]   DEPTH_L   = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'((1 << SECT_W) - 1);
  localparam logic [ADDR_W-1:0] SBLK_MASK = ~ADDR_W'((1 << SBLK_W) - 1);
  localparam logic [ADDR_W-1:0] LBLK_MASK = ~ADDR_W'((1 << LBLK_W) - 1);

  // synchronised bus pins: bit 2 chip select, bit 1 serial clock, bit 0 data
  logic [2:0] pin_q, pin_rise, pin_fall;
  spif_sampler #(.N(3), .RST_VAL(3'b100)) u_sampler (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, si}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );
  logic cs_q, si_q, cs_rise, sck_rise, sck_fall;
  assign cs_q     = pin_q[2];
  assign si_q     = pin_q[0];
  assign cs_rise  = pin_rise[2];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  logic unused_pins;
  assign unused_pins = ^{pin_q[1], pin_rise[0], pin_fall[2], pin_fall[0]};

  // frame state
  logic [6:0]        bit_cnt;
  logic [6:0]        sh;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata;
  logic              ign;
  logic              out_act;
  logic [6:0]        tx;
  logic [2:0]        tx_cnt;
  logic [ADDR_W-1:0] rd_ptr;
  logic [1:0]        id_idx;
  logic              so_q;

  // status
  logic             busy, wel;
  logic [2:0]       bp;
  logic [CNT_W-1:0] busy_cnt;
  logic             arr_wait;

  // array port
  logic              req_valid, req_ready, arr_done;
  arr_op_e           req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [ADDR_W:0]   req_len;
  logic [7:0]        req_data;
  logic [7:0]        rd_data;

  logic [7:0] new_byte, status_b, nxt;
  logic       byte_done;
  logic [3:0] byte_idx;

  assign new_byte  = {sh, si_q};
  assign byte_done = sck_rise && (bit_cnt[2:0] == 3'd7);
  assign byte_idx  = bit_cnt[6:3];
  assign status_b  = {3'b000, bp, wel, busy};

  always_comb begin
    unique case (opcode)
      OP_READ: nxt = rd_data;
      OP_RDSR: nxt = status_b;
      OP_JID:  nxt = (id_idx == 2'd0) ? MFR_ID :
                     (id_idx == 2'd1) ? DEV_ID[15:8] : DEV_ID[7:0];
      OP_IDA, OP_IDB: nxt = (addr_q[0] ^ id_idx[0]) ? DEV_ID[7:0] : MFR_ID;
      default: nxt = 8'h00;
    endcase
  end

  // serial shift-in and reply shift-out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      opcode  <= '0;
      addr_q  <= '0;
      wdata   <= '0;
      ign     <= 1'b0;
      out_act <= 1'b0;
      tx      <= '0;
      tx_cnt  <= '0;
      rd_ptr  <= '0;
      id_idx  <= '0;
      so_q    <= 1'b0;
    end else if (cs_q) begin
      bit_cnt <= '0;
      ign     <= 1'b0;
      out_act <= 1'b0;
      tx_cnt  <= '0;
      so_q    <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh <= {sh[5:0], si_q};
        if (bit_cnt != 7'h7F) bit_cnt <= bit_cnt + 7'd1;
        if (byte_done) begin
          wdata <= new_byte;
          if (byte_idx == 4'd0) begin
            opcode <= new_byte;
            ign    <= busy && (new_byte != OP_RDSR);
            id_idx <= '0;
            if ((new_byte == OP_RDSR) || (new_byte == OP_JID && !busy))
              out_act <= 1'b1;
          end else if (byte_idx <= 4'd3) begin
            addr_q <= ADDR_W'({addr_q, new_byte});
            if (byte_idx == 4'd3 && !ign &&
                (opcode == OP_READ || opcode == OP_IDA || opcode == OP_IDB)) begin
              out_act <= 1'b1;
              rd_ptr  <= ADDR_W'({addr_q, new_byte});
            end
          end
        end
      end
      if (sck_fall && out_act) begin
        tx_cnt <= tx_cnt + 3'd1;
        if (tx_cnt == 3'd0) begin
          so_q   <= nxt[7];
          tx     <= nxt[6:0];
          rd_ptr <= rd_ptr + ADDR_W'(1);
          id_idx <= (opcode == OP_JID && id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
        end else begin
          so_q <= tx[6];
          tx   <= {tx[5:0], 1'b0};
        end
      end
    end
  end

  assign so    = so_q;
  assign so_en = out_act & ~cs_q;

  // command execution at chip-select release
  logic is_wrsr, is_prog, is_sect, is_sblk, is_lblk, is_chip, go_wren, go_wrdi;
  logic [ADDR_W-1:0] g_start;
  logic [ADDR_W:0]   g_len;
  logic              g_hit, accept;

  always_comb begin
    is_wrsr = (opcode == OP_WRSR) && (bit_cnt == 7'd16);
    is_prog = (opcode == OP_PROG) && (bit_cnt == 7'd40);
    is_sect = (opcode == OP_SECT) && (bit_cnt == 7'd32);
    is_sblk = (opcode == OP_SBLK) && (bit_cnt == 7'd32);
    is_lblk = (opcode == OP_LBLK) && (bit_cnt == 7'd32);
    is_chip = (opcode == OP_CHPA || opcode == OP_CHPB) && (bit_cnt == 7'd8);
    go_wren = cs_rise && !busy && (opcode == OP_WREN) && (bit_cnt == 7'd8);
    go_wrdi = cs_rise && !busy && (opcode == OP_WRDI) && (bit_cnt == 7'd8);
    g_start = addr_q;
    g_len   = (ADDR_W+1)'(1);
    if (is_sect) begin
      g_start = addr_q & SECT_MASK;
      g_len   = (ADDR_W+1)'(1) << SECT_W;
    end else if (is_sblk) begin
      g_start = addr_q & SBLK_MASK;
      g_len   = (ADDR_W+1)'(1) << SBLK_W;
    end else if (is_lblk) begin
      g_start = addr_q & LBLK_MASK;
      g_len   = (ADDR_W+1)'(1) << LBLK_W;
    end else if (is_chip) begin
      g_start = '0;
      g_len   = DEPTH_L;
    end
    accept = cs_rise && !busy && wel &&
             (is_wrsr ||
              ((is_prog || is_sect || is_sblk || is_lblk) && !g_hit) ||
              (is_chip && bp == 3'd0));
  end

  spif_guard #(.ADDR_W(ADDR_W)) u_guard (
    .level(bp), .start(g_start), .len(g_len), .hit(g_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wel       <= 1'b0;
      bp        <= 3'd0;
      busy_cnt  <= '0;
      arr_wait  <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= ARR_PROG;
      req_addr  <= '0;
      req_len   <= '0;
      req_data  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      busy_cnt <= '0;
      if (is_wrsr) begin
        bp <= wdata[4:2];
      end else begin
        req_valid <= 1'b1;
        arr_wait  <= 1'b1;
        req_op    <= is_prog ? ARR_PROG : ARR_ERASE;
        req_addr  <= g_start;
        req_len   <= g_len;
        req_data  <= wdata;
      end
    end else if (busy) begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (arr_done) arr_wait <= 1'b0;
      if (busy_cnt != CNT_W'(BUSY_CYCLES)) busy_cnt <= busy_cnt + CNT_W'(1);
      else if (!arr_wait && !req_valid) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
    end else begin
      if (go_wren) wel <= 1'b1;
      if (go_wrdi) wel <= 1'b0;
    end
  end

  spif_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .done(arr_done), .rd_addr(rd_ptr), .rd_data(rd_data)
  );

  AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel); // R12
  AST_LEVEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bp) |-> $past(wel)); // R7
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> busy); // R12
  AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) ign |-> !out_act); // R13
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_q) |=> (!so && !so_en)); // R2
endmodule

// File: tb/test_spif_cmd_front.sv
module test_spif_cmd_front;
  localparam int HP = 6;
  localparam logic [15:0] DEV = 16'h2514;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  wire  so, so_en;

  always #5 clk = ~clk;

  spif_cmd_front #(.DEV_ID(DEV), .BUSY_CYCLES(2000)) i_spif_cmd_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_byte;
  bit         rx_pend = 1'b0;
  bit         mode3 = 1'b0;
  bit         saw_en = 1'b0;
  bit         done_run = 1'b0;

  // monitor: pops the scoreboard whenever a reply byte arrives
  always @(posedge clk) begin
    if (rx_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rx_byte !== e) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", t, rx_byte, e);
      end
      rx_pend = 1'b0;
    end
  end

  always @(negedge clk) if (!cs_n && so_en) saw_en = 1'b1;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic begin_cmd();
    sck = mode3;
    wt(2);
    cs_n = 1'b0;
    wt(4);
  endtask

  task automatic end_cmd();
    wt(3);
    if (!mode3) sck = 1'b0;
    wt(4);
    cs_n = 1'b1;
    wt(8);
  endtask

  task automatic xfer(input logic [7:0] tv, output logic [7:0] rv);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tv[i];
      wt(HP);
      rv[i] = so;
      sck = 1'b1;
      wt(HP);
    end
  endtask

  task automatic put(input logic [7:0] tv);
    logic [7:0] r;
    xfer(tv, r);
  endtask

  task automatic put_addr(input logic [23:0] a);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask

  // driver: pushes the expected item, clocks the byte, hands it to the monitor
  task automatic expect_rx(input logic [7:0] e, input string t);
    logic [7:0] r;
    exp_q.push_back(e);
    tag_q.push_back(t);
    xfer(8'h00, r);
    rx_byte = r;
    rx_pend = 1'b1;
    while (rx_pend) @(negedge clk);
  endtask

  task automatic simple(input logic [7:0] op);
    begin_cmd(); put(op); end_cmd();
  endtask

  task automatic status_is(input logic [7:0] e, input string t);
    begin_cmd(); put(8'h05); expect_rx(e, t); end_cmd();
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    begin_cmd();
    put(8'h05);
    for (int k = 0; k < 400; k++) begin
      xfer(8'h00, r);
      if (!r[0]) break;
    end
    end_cmd();
  endtask

  task automatic read_start(input logic [23:0] a);
    begin_cmd(); put(8'h03); put_addr(a);
  endtask

  task automatic read1(input logic [23:0] a, input logic [7:0] e, input string t);
    read_start(a); expect_rx(e, t); end_cmd();
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    simple(8'h06);
    begin_cmd(); put(8'h02); put_addr(a); put(d); end_cmd();
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a);
    simple(8'h06);
    begin_cmd(); put(op); put_addr(a); end_cmd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: got %02h expected %02h", 8'h00, 8'h01);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wt(6);
    rst_n = 1'b1;
    wt(6);
    check(!so_en && !so, "R2 idle after reset", {6'd0, so_en, so}, 8'h00);
    status_is(8'h00, "R5 R8 reset status");

    // identification, JEDEC query in mode 3
    mode3 = 1'b1;
    begin_cmd(); put(8'h9F);
    expect_rx(8'hBF, "R1 R4 mode3 mfr");
    expect_rx(DEV[15:8], "R4 dev hi");
    expect_rx(DEV[7:0], "R4 dev lo");
    expect_rx(8'hBF, "R4 repeat");
    end_cmd();
    mode3 = 1'b0;
    begin_cmd(); put(8'h90); put_addr(24'h000000);
    expect_rx(8'hBF, "R4 90h first");
    expect_rx(DEV[7:0], "R4 90h second");
    expect_rx(8'hBF, "R4 90h third");
    end_cmd();
    begin_cmd(); put(8'hAB); put_addr(24'h000001);
    expect_rx(DEV[7:0], "R4 ABh odd first");
    expect_rx(8'hBF, "R4 ABh odd second");
    end_cmd();
    check(!so_en && !so, "R2 quiet between frames", {6'd0, so_en, so}, 8'h00);

    // latch control
    simple(8'h60);
    status_is(8'h00, "R7 chip erase without latch");
    simple(8'h06);
    status_is(8'h02, "R6 WREN sets latch");
    simple(8'h04);
    status_is(8'h00, "R6 WRDI clears latch");
    begin_cmd(); put(8'h06); put(8'h00); end_cmd();
    status_is(8'h00, "R6 WREN wrong length");

    // chip erase, busy behaviour
    simple(8'h06);
    simple(8'h60);
    begin_cmd(); put(8'h05);
    expect_rx(8'h03, "R12 busy after chip erase");
    expect_rx(8'h03, "R5 repeated status");
    end_cmd();
    simple(8'h06);
    saw_en = 1'b0;
    read_start(24'h000000); put(8'h00); put(8'h00); end_cmd();
    check(!saw_en, "R13 read ignored while busy", {7'd0, saw_en}, 8'h00);
    wait_ready();
    status_is(8'h00, "R12 R13 latch cleared, WREN ignored");
    read_start(24'h0003FE);
    expect_rx(8'hFF, "R10 chip erased");
    expect_rx(8'hFF, "R10 chip erased top");
    end_cmd();

    // program
    prog(24'h000000, 8'hA5); wait_ready();
    read1(24'h000000, 8'hA5, "R9 program");
    prog(24'h000000, 8'h3C); wait_ready();
    read1(24'h000000, 8'h24, "R9 program ANDs");
    prog(24'h0003FF, 8'h5A); wait_ready();
    read_start(24'h0003FF);
    expect_rx(8'h5A, "R3 top byte");
    expect_rx(8'h24, "R3 wrap to zero");
    end_cmd();
    read1(24'hFFFC00, 8'h24, "R3 upper address bits ignored");

    simple(8'h06);
    begin_cmd(); put(8'h02); put_addr(24'h000010); put(8'h00); put(8'h00); end_cmd();
    status_is(8'h02, "R7 program wrong length dropped");
    simple(8'h04);
    read1(24'h000010, 8'hFF, "R7 byte untouched");

    // protection level 1: top 16 bytes guarded
    simple(8'h06);
    begin_cmd(); put(8'h01); put(8'h04); end_cmd();
    status_is(8'h07, "R12 status write busy");
    wait_ready();
    status_is(8'h04, "R8 level loaded");
    prog(24'h0003F8, 8'h00);
    status_is(8'h06, "R11 guarded program dropped");
    simple(8'h04);
    read1(24'h0003F8, 8'hFF, "R11 guarded byte kept");
    prog(24'h0003EF, 8'h00); wait_ready();
    read1(24'h0003EF, 8'h00, "R11 unguarded program");
    erase(8'h20, 24'h0003C0);
    status_is(8'h06, "R11 guarded sector dropped");
    simple(8'h04);
    read1(24'h0003FF, 8'h5A, "R11 guarded data kept");
    erase(8'h60, 24'h000000);
    status_is(8'h06, "R11 chip erase refused");
    simple(8'h04);

    // region sizes
    prog(24'h000385, 8'h11); wait_ready();
    erase(8'h20, 24'h0003A7); wait_ready();
    read1(24'h000385, 8'hFF, "R10 sector erased");
    read1(24'h0003EF, 8'h00, "R10 next sector kept");
    prog(24'h0000FF, 8'h77); wait_ready();
    prog(24'h000100, 8'h66); wait_ready();
    erase(8'h52, 24'h000040); wait_ready();
    read1(24'h000000, 8'hFF, "R10 small block erased");
    read1(24'h0000FF, 8'h77, "R10 small block bound");
    erase(8'hD8, 24'h000080); wait_ready();
    read_start(24'h0000FF);
    expect_rx(8'hFF, "R10 large block erased");
    expect_rx(8'h66, "R10 large block bound");
    end_cmd();

    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule